// File: doc/BRIEF.md
# Mesh Route and VC-Class Selector

This block decides, for each head flit, which output port a packet takes out of a 2D mesh router and which virtual-channel class it asks for downstream. The router also sits on a unidirectional bypass ring. The VCs on that ring form the escape class, and every other VC is adaptive. The selector sees the current node and destination coordinates, the packet's present class, and the number of non-minimal hops it has already taken. It also sees which mesh output ports currently have room.

An adaptive packet first tries a productive (distance-reducing) mesh port, with X preferred over Y. If neither is open, it detours through one non-productive mesh port and its misroute count goes up by one. Once that count reaches a configured limit, the packet is moved onto the ring in the escape class. A packet already in the escape class stays on the ring until it is home. A packet at its destination always ejects locally. The decision is registered and appears one cycle after the head flit is presented.

Top module: `vc_route_sel`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_valid` falls in the next cycle and `out_port`, `out_cls` and `out_cnt` hold their previous values.
- R2: If the current coordinates equal the destination, the selected port is local ejection (code 0). The class (0 adaptive, 1 escape) and the count pass through unchanged.
- R3: A packet in the escape class (1) that is not at its destination takes the ring port (code 5), stays in class 1 and keeps its count.
- R4: An adaptive packet (class 0) that is not at its destination and whose count is at or above `MISROUTE_LIMIT` takes the ring port (code 5), moves to class 1 and keeps its count.
- R5: Otherwise, if the productive X port is usable, it is chosen, even when a productive Y port is also usable. Port codes are 1 (+X), 2 (-X), 3 (+Y) and 4 (-Y). Free flag bits are bit0 +X, bit1 -X, bit2 +Y and bit3 -Y. The class stays 0 and the count is unchanged.
- R6: If no productive X port is usable, or X needs no movement, a usable productive Y port is chosen. The class stays 0 and the count is unchanged.
- R7: If no productive port is usable, the first usable non-productive mesh port in the order +X, -X, +Y, -Y is chosen. The class stays 0 and the count rises by one, saturating at all ones (15 for a 4-bit count).
- R8: A mesh port that leaves the mesh edge (-X at x=0, +X at x=MESH_X-1, -Y at y=0, +Y at y=MESH_Y-1) is never chosen, even if its free flag is set.
- R9: If no mesh port is usable for an adaptive packet below the limit, it takes the ring port (code 5), moves to class 1 and keeps its count.
- R10: During and right after synchronous reset, `out_valid` is low, and the other outputs read port 0, class 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head flit present this cycle |
| in_cur_x | input | XW | Current node X |
| in_cur_y | input | YW | Current node Y |
| in_dst_x | input | XW | Destination X |
| in_dst_y | input | YW | Destination Y |
| in_cls | input | 1 | Present VC class, 0 adaptive, 1 escape |
| in_cnt | input | CNT_W | Misroute hops taken so far |
| in_free | input | 4 | Mesh port has room: bit0 +X, bit1 -X, bit2 +Y, bit3 -Y |
| out_valid | output | 1 | Registered decision valid |
| out_port | output | 3 | 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y, 5 ring |
| out_cls | output | 1 | Class to request downstream |
| out_cnt | output | CNT_W | Updated misroute count |

## Verification
The bench builds two copies on a 4x4 mesh with a 4-bit count. The main instance uses a limit of 3, so the forced switch to escape occurs at a small count and can be probed on both sides of the limit. The second instance uses a limit of 16, which can never be reached. With it, a detour from counts 14 and 15 shows the saturating increment, which the low limit would hide behind the ring fallback. Corner nodes at the mesh edges show that an off-mesh free flag is ignored.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XPOS  = 3'd1,
    PORT_XNEG  = 3'd2,
    PORT_YPOS  = 3'd3,
    PORT_YNEG  = 3'd4,
    PORT_RING  = 3'd5
  } port_e;

  typedef enum logic {
    CLS_ADAPT  = 1'b0,
    CLS_ESCAPE = 1'b1
  } vc_cls_e;

  localparam int NUM_DIRS = 4;

  // mesh direction index d maps to port code d+1
  function automatic port_e dir_to_port(input logic [1:0] d);
    return port_e'({1'b0, d} + 3'd1);
  endfunction

endpackage

// File: rtl/route_dir_calc.sv
module route_dir_calc #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int XW     = 2,
  parameter int YW     = 2
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic          at_dest,
  output logic [3:0]    productive,
  output logic [3:0]    in_mesh
);

  localparam logic [XW-1:0] X_MAX = XW'(MESH_X - 1);
  localparam logic [YW-1:0] Y_MAX = YW'(MESH_Y - 1);

  assign at_dest = (cur_x == dst_x) && (cur_y == dst_y);

  assign productive[0] = dst_x > cur_x;
  assign productive[1] = dst_x < cur_x;
  assign productive[2] = dst_y > cur_y;
  assign productive[3] = dst_y < cur_y;

  // edge masks: one existence test per mesh direction
  for (genvar d = 0; d < 4; d++) begin : g_edge
    if (d == 0) begin : g_xpos
      assign in_mesh[d] = cur_x != X_MAX;
    end else if (d == 1) begin : g_xneg
      assign in_mesh[d] = cur_x != '0;
    end else if (d == 2) begin : g_ypos
      assign in_mesh[d] = cur_y != Y_MAX;
    end else begin : g_yneg
      assign in_mesh[d] = cur_y != '0;
    end
  end

endmodule

// File: rtl/route_pick.sv
module route_pick (
  input  logic [3:0] productive,
  input  logic [3:0] usable,
  output logic       min_ok,
  output logic [1:0] min_dir,
  output logic       det_ok,
  output logic [1:0] det_dir
);

  logic [3:0] min_cand;
  logic [3:0] det_cand;

  assign min_cand = productive & usable;
  assign det_cand = ~productive & usable;

  // index order gives X before Y for minimal hops, and
  // +X, -X, +Y, -Y for detours
  always_comb begin
    min_ok  = 1'b0;
    min_dir = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (min_cand[i]) begin
        min_ok  = 1'b1;
        min_dir = 2'(i);
      end
    end
  end

  always_comb begin
    det_ok  = 1'b0;
    det_dir = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (det_cand[i]) begin
        det_ok  = 1'b1;
        det_dir = 2'(i);
      end
    end
  end

endmodule

// File: rtl/vc_route_sel.sv
module vc_route_sel
  import route_sel_pkg::*;
#(
  parameter int MESH_X         = 4,
  parameter int MESH_Y         = 4,
  parameter int CNT_W          = 4,
  parameter int MISROUTE_LIMIT = 3,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XW-1:0]    in_cur_x,
  input  logic [YW-1:0]    in_cur_y,
  input  logic [XW-1:0]    in_dst_x,
  input  logic [YW-1:0]    in_dst_y,
  input  logic             in_cls,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [3:0]       in_free,
  output logic             out_valid,
  output logic [2:0]       out_port,
  output logic             out_cls,
  output logic [CNT_W-1:0] out_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       at_dest;
  logic [3:0] productive;
  logic [3:0] in_mesh;
  logic [3:0] usable;
  logic       min_ok, det_ok;
  logic [1:0] min_dir, det_dir;
  logic       over_limit;

  port_e            nxt_port;
  vc_cls_e          nxt_cls;
  logic [CNT_W-1:0] nxt_cnt;

  route_dir_calc #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW)
  ) u_dir (
    .cur_x      (in_cur_x),
    .cur_y      (in_cur_y),
    .dst_x      (in_dst_x),
    .dst_y      (in_dst_y),
    .at_dest    (at_dest),
    .productive (productive),
    .in_mesh    (in_mesh)
  );

  assign usable = in_free & in_mesh;

  route_pick u_pick (
    .productive (productive),
    .usable     (usable),
    .min_ok     (min_ok),
    .min_dir    (min_dir),
    .det_ok     (det_ok),
    .det_dir    (det_dir)
  );

  assign over_limit = int'(in_cnt) >= MISROUTE_LIMIT;

  always_comb begin
    nxt_port = PORT_RING;
    nxt_cls  = CLS_ESCAPE;
    nxt_cnt  = in_cnt;
    if (at_dest) begin
      nxt_port = PORT_LOCAL;
      nxt_cls  = vc_cls_e'(in_cls);
    end else if (in_cls == CLS_ESCAPE || over_limit) begin
      nxt_port = PORT_RING;
      nxt_cls  = CLS_ESCAPE;
    end else if (min_ok) begin
      nxt_port = dir_to_port(min_dir);
      nxt_cls  = CLS_ADAPT;
    end else if (det_ok) begin
      nxt_port = dir_to_port(det_dir);
      nxt_cls  = CLS_ADAPT;
      nxt_cnt  = (in_cnt == CNT_MAX) ? in_cnt : in_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= PORT_LOCAL;
      out_cls   <= CLS_ADAPT;
      out_cnt   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port <= nxt_port;
        out_cls  <= nxt_cls;
        out_cnt  <= nxt_cnt;
      end
    end
  end

endmodule

// File: rtl/vc_route_sel_chk.sv
module vc_route_sel_chk #(
  parameter int XW    = 2,
  parameter int YW    = 2,
  parameter int CNT_W = 4,
  parameter int LIMIT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [XW-1:0]    in_cur_x,
  input logic [YW-1:0]    in_cur_y,
  input logic [XW-1:0]    in_dst_x,
  input logic [YW-1:0]    in_dst_y,
  input logic             in_cls,
  input logic [CNT_W-1:0] in_cnt,
  input logic             out_valid,
  input logic [2:0]       out_port,
  input logic             out_cls,
  input logic [CNT_W-1:0] out_cnt
);

  logic home;
  assign home = (in_cur_x == in_dst_x) && (in_cur_y == in_dst_y);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_port) && $stable(out_cnt));

  p_eject_home_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && home |=> out_port == 3'd0);

  p_escape_stays_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cls && !home |=> out_port == 3'd5 && out_cls);

  p_force_escape_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_cls && !home && int'(in_cnt) >= LIMIT
    |=> out_port == 3'd5 && out_cls && out_cnt == $past(in_cnt));

  p_mesh_adaptive_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_port >= 3'd1 && out_port <= 3'd4 |-> !out_cls);

  p_no_west_edge_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cur_x == '0 |=> out_port != 3'd2);

  p_no_south_edge_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_cur_y == '0 |=> out_port != 3'd4);

  p_port_range_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_port <= 3'd5);

endmodule

bind vc_route_sel vc_route_sel_chk #(
  .XW(XW), .YW(YW), .CNT_W(CNT_W), .LIMIT(MISROUTE_LIMIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_cur_x  (in_cur_x),
  .in_cur_y  (in_cur_y),
  .in_dst_x  (in_dst_x),
  .in_dst_y  (in_dst_y),
  .in_cls    (in_cls),
  .in_cnt    (in_cnt),
  .out_valid (out_valid),
  .out_port  (out_port),
  .out_cls   (out_cls),
  .out_cnt   (out_cnt)
);

// File: tb/tb_vc_route_sel.sv
module tb_vc_route_sel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] cx = '0, cy = '0, dx = '0, dy = '0;
  logic       cls = 1'b0;
  logic [3:0] cnt = '0;
  logic [3:0] free = '0;

  logic       ov, oc, ov2, oc2;
  logic [2:0] op, op2;
  logic [3:0] on, on2;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vc_route_sel #(.MESH_X(4), .MESH_Y(4), .CNT_W(4), .MISROUTE_LIMIT(3)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_cur_x(cx), .in_cur_y(cy), .in_dst_x(dx), .in_dst_y(dy),
    .in_cls(cls), .in_cnt(cnt), .in_free(free),
    .out_valid(ov), .out_port(op), .out_cls(oc), .out_cnt(on)
  );

  vc_route_sel #(.MESH_X(4), .MESH_Y(4), .CNT_W(4), .MISROUTE_LIMIT(16)) dut_nolim (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_cur_x(cx), .in_cur_y(cy), .in_dst_x(dx), .in_dst_y(dy),
    .in_cls(cls), .in_cnt(cnt), .in_free(free),
    .out_valid(ov2), .out_port(op2), .out_cls(oc2), .out_cnt(on2)
  );

  task automatic expect_out(input string req, input logic v, input logic [2:0] p,
                            input logic c, input logic [3:0] n, input bit alt);
    logic av, ac;
    logic [2:0] ap;
    logic [3:0] an;
    av = alt ? ov2 : ov;
    ap = alt ? op2 : op;
    ac = alt ? oc2 : oc;
    an = alt ? on2 : on;
    checks++;
    if (av !== v || ap !== p || ac !== c || an !== n) begin
      failures++;
      $display("FAIL %s: got valid=%0b port=%0d cls=%0b cnt=%0d, expected valid=%0b port=%0d cls=%0b cnt=%0d",
               req, av, ap, ac, an, v, p, c, n);
    end
  endtask

  // present one head flit, wait for the register, sample on the falling edge
  task automatic present(input logic [1:0] x, input logic [1:0] y,
                         input logic [1:0] tx, input logic [1:0] ty,
                         input logic k, input logic [3:0] m, input logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1;
    cx = x; cy = y; dx = tx; dy = ty; cls = k; cnt = m; free = f;
    @(negedge clk);
  endtask

  task automatic t_reset_r10();
    expect_out("R10", 1'b0, 3'd0, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_eject_r2();
    present(2'd1, 2'd1, 2'd1, 2'd1, 1'b1, 4'd5, 4'hF);
    expect_out("R2 escape home", 1'b1, 3'd0, 1'b1, 4'd5, 1'b0);
    present(2'd2, 2'd3, 2'd2, 2'd3, 1'b0, 4'd1, 4'h0);
    expect_out("R2 adaptive home", 1'b1, 3'd0, 1'b0, 4'd1, 1'b0);
  endtask

  task automatic t_escape_r3();
    present(2'd0, 2'd0, 2'd3, 2'd3, 1'b1, 4'd2, 4'hF);
    expect_out("R3", 1'b1, 3'd5, 1'b1, 4'd2, 1'b0);
  endtask

  task automatic t_minimal_r5_r6();
    present(2'd1, 2'd1, 2'd3, 2'd2, 1'b0, 4'd0, 4'hF);
    expect_out("R5 X preferred", 1'b1, 3'd1, 1'b0, 4'd0, 1'b0);
    present(2'd1, 2'd1, 2'd3, 2'd2, 1'b0, 4'd0, 4'b1110);
    expect_out("R6 X busy", 1'b1, 3'd3, 1'b0, 4'd0, 1'b0);
    present(2'd1, 2'd1, 2'd1, 2'd3, 1'b0, 4'd2, 4'hF);
    expect_out("R6 Y only", 1'b1, 3'd3, 1'b0, 4'd2, 1'b0);
    present(2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 4'd0, 4'b1101);
    expect_out("R6 -Y when -X busy", 1'b1, 3'd4, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_detour_r7();
    present(2'd1, 2'd1, 2'd3, 2'd3, 1'b0, 4'd1, 4'b0010);
    expect_out("R7 detour -X", 1'b1, 3'd2, 1'b0, 4'd2, 1'b0);
    present(2'd1, 2'd1, 2'd3, 2'd1, 1'b0, 4'd0, 4'b1010);
    expect_out("R7 order -X before -Y", 1'b1, 3'd2, 1'b0, 4'd1, 1'b0);
    present(2'd1, 2'd1, 2'd3, 2'd1, 1'b0, 4'd0, 4'b1100);
    expect_out("R7 order +Y before -Y", 1'b1, 3'd3, 1'b0, 4'd1, 1'b0);
    present(2'd1, 2'd1, 2'd3, 2'd3, 1'b0, 4'd14, 4'b0010);
    expect_out("R7 increment to max", 1'b1, 3'd2, 1'b0, 4'd15, 1'b1);
    present(2'd1, 2'd1, 2'd3, 2'd3, 1'b0, 4'd15, 4'b0010);
    expect_out("R7 saturate", 1'b1, 3'd2, 1'b0, 4'd15, 1'b1);
  endtask

  task automatic t_limit_r4();
    present(2'd1, 2'd1, 2'd3, 2'd3, 1'b0, 4'd2, 4'hF);
    expect_out("R4 below limit", 1'b1, 3'd1, 1'b0, 4'd2, 1'b0);
    present(2'd1, 2'd1, 2'd3, 2'd3, 1'b0, 4'd3, 4'hF);
    expect_out("R4 at limit", 1'b1, 3'd5, 1'b1, 4'd3, 1'b0);
    present(2'd1, 2'd1, 2'd3, 2'd3, 1'b0, 4'd9, 4'hF);
    expect_out("R4 above limit", 1'b1, 3'd5, 1'b1, 4'd9, 1'b0);
  endtask

  task automatic t_edge_r8_r9();
    present(2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 4'd1, 4'b1010);
    expect_out("R8 off-mesh flags ignored", 1'b1, 3'd5, 1'b1, 4'd1, 1'b0);
    present(2'd3, 2'd0, 2'd3, 2'd2, 1'b0, 4'd0, 4'b0011);
    expect_out("R8 +X off edge skipped", 1'b1, 3'd2, 1'b0, 4'd1, 1'b0);
    present(2'd1, 2'd1, 2'd2, 2'd2, 1'b0, 4'd2, 4'b0000);
    expect_out("R9 nothing free", 1'b1, 3'd5, 1'b1, 4'd2, 1'b0);
  endtask

  task automatic t_hold_r1();
    present(2'd1, 2'd1, 2'd3, 2'd2, 1'b0, 4'd0, 4'hF);
    expect_out("R1 valid after flit", 1'b1, 3'd1, 1'b0, 4'd0, 1'b0);
    in_valid = 1'b0;
    cx = 2'd2; cy = 2'd2; dx = 2'd2; dy = 2'd2; cnt = 4'd7;
    @(negedge clk);
    expect_out("R1 idle holds", 1'b0, 3'd1, 1'b0, 4'd0, 1'b0);
    @(negedge clk);
    expect_out("R1 idle second cycle", 1'b0, 3'd1, 1'b0, 4'd0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r10();
    rst = 1'b0;
    @(negedge clk);
    t_reset_r10();
    t_eject_r2();
    t_escape_r3();
    t_minimal_r5_r6();
    t_detour_r7();
    t_limit_r4();
    t_edge_r8_r9();
    t_hold_r1();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule